// File: doc/BRIEF.md
# Host Interrupt Status Aggregator

This block gathers event pulses from the on-chip sources into one 16-bit status register that the host can read. DMA channels, mailboxes, wake-up detectors and bus-abort detectors each drive a pulse. A pulse sets a sticky bit, and the host clears that bit by writing a 1 to it. Every enabled status bit feeds one shared active-low interrupt line. That line comes from a flop, so it cannot glitch.

The block also has a periodic down-counter. Writing a base count loads both the base and the running count. When the count would reach zero, the counter raises a sticky timer flag and reloads itself from the base, so the flag is raised once every base-count cycles. A base of zero stops the counter. The timer flag has its own enable input for the interrupt line.

Registers sit behind a 2-bit address with full 16-bit writes and combinational readback:

| Address | Register |
|---|---|
| 0 | status |
| 1 | base count |
| 2 | running count (read only) |
| 3 | timer flag, in bit 0 |

Top module: `hirq_aggr`

## Requirements
- R1: A pulse on `ev_i[n]` sets status bit n on the next clock edge, for n in {1..8, 11..14}. Bits 1–4 are DMA receive 0, receive 1, transmit 0 and transmit 1. Bits 5–6 are incoming mailboxes 0/1. Bits 7–8 are outgoing mailboxes 0/1. Bit 11 is the I/O pin wake-up, bit 12 the AC'97 link wake-up, bit 13 the master abort and bit 14 the target abort. A set bit stays set.
- R2: Status bits 0, 9, 10 and 15 always read 0. Pulses on the matching `ev_i` bits have no effect.
- R3: A write to address 0 clears each status bit whose data bit is 1. Bits written with 0 keep their value.
- R4: A clearing write and an event on the same bit in the same cycle leave the bit set.
- R5: `irq_n_o` is low exactly when a status bit is set whose `en_i` bit is 1, or when the timer flag is set and `tmr_en_i` is 1. Disabled bits do not pull the line low.
- R6: `irq_n_o` is registered. It follows the status one clock edge after the status changes.
- R7: Writing B to address 1 loads both the base and the running count (read at address 2) with B. With B nonzero, the count falls by one per cycle. On the edge where it would reach zero, the counter sets the timer flag and reloads B, so the flag is raised every B cycles.
- R8: With a base of zero, the running count stays 0 and the timer flag is never set.
- R9: The timer flag reads in bit 0 of address 3. Writing 1 to that bit clears the flag, but an expiry in the same cycle wins.
- R10: After reset, the status, base, count and timer flag are all 0, and `irq_n_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_i | input | 16 | Event pulses, one per status bit position |
| en_i | input | 16 | Interrupt enable per status bit |
| tmr_en_i | input | 1 | Interrupt enable for the timer flag |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 16 | Register write data |
| rdata_o | output | 16 | Register read data for `addr_i` |
| irq_n_o | output | 1 | Active-low host interrupt |

## Verification
A corrupted status bit appears at address 0 on the first read after the faulty edge. If that bit is enabled, `irq_n_o` also shows it one edge later. A wrong running count shows at address 2 at once. A missed or extra reload shows as the timer flag rising on the wrong edge, one cycle off or a whole period off. The bench samples these values on exact cycles, so an off-by-one in the period or in the pin register is caught.

// File: rtl/hirq_pkg.sv
package hirq_pkg;
    localparam int STAT_W = 16;
    localparam int ADDR_W = 2;
    // implemented status positions: 1..8 and 11..14
    localparam logic [STAT_W-1:0] SRC_MASK = 16'h79FE;

    typedef enum logic [ADDR_W-1:0] {
        A_STAT  = 2'd0,
        A_BASE  = 2'd1,
        A_CNT   = 2'd2,
        A_TFLAG = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/hirq_status.sv
module hirq_status
    import hirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] ev_i,
    input  logic [STAT_W-1:0] clr_i,
    output logic [STAT_W-1:0] stat_o
);
    typedef struct packed {
        logic [STAT_W-1:0] stat;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // clear first, then set: an event in the same cycle wins
        st_d.stat = (st_q.stat & ~clr_i) | (ev_i & SRC_MASK);
        st_d.stat = st_d.stat & SRC_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat_o = st_q.stat;
endmodule

// File: rtl/hirq_timer.sv
module hirq_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             base_wr_i,
    input  logic [CNT_W-1:0] base_i,
    input  logic             flag_clr_i,
    output logic [CNT_W-1:0] base_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             flag_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] base;
        logic [CNT_W-1:0] cnt;
        logic             flag;
    } tm_t;

    tm_t tm_d, tm_q;
    logic expire;

    always_comb begin
        tm_d   = tm_q;
        expire = 1'b0;
        if (base_wr_i) begin
            tm_d.base = base_i;
            tm_d.cnt  = base_i;
        end else if (tm_q.base != '0) begin
            if (tm_q.cnt == ONE) begin
                expire   = 1'b1;
                tm_d.cnt = tm_q.base;
            end else begin
                tm_d.cnt = tm_q.cnt - ONE;
            end
        end
        if (flag_clr_i) tm_d.flag = 1'b0;
        if (expire)     tm_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tm_q <= '0;
        else        tm_q <= tm_d;
    end

    assign base_o = tm_q.base;
    assign cnt_o  = tm_q.cnt;
    assign flag_o = tm_q.flag;
endmodule

// File: rtl/hirq_pin.sv
module hirq_pin
    import hirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] stat_i,
    input  logic [STAT_W-1:0] en_i,
    input  logic              tflag_i,
    input  logic              ten_i,
    output logic              irq_n_o
);
    typedef struct packed {
        logic irq_n;
    } pin_t;

    pin_t pin_d, pin_q;

    always_comb begin
        pin_d       = pin_q;
        pin_d.irq_n = ~((|(stat_i & en_i)) | (tflag_i & ten_i));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pin_q <= '{irq_n: 1'b1};
        else        pin_q <= pin_d;
    end

    assign irq_n_o = pin_q.irq_n;
endmodule

// File: rtl/hirq_aggr.sv
module hirq_aggr
    import hirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] ev_i,
    input  logic [STAT_W-1:0] en_i,
    input  logic              tmr_en_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [STAT_W-1:0] wdata_i,
    output logic [STAT_W-1:0] rdata_o,
    output logic              irq_n_o
);
    logic [STAT_W-1:0] stat_q;
    logic [STAT_W-1:0] base_q;
    logic [STAT_W-1:0] cnt_q;
    logic              tflag_q;
    logic [STAT_W-1:0] stat_clr;
    logic              base_wr;
    logic              tflag_clr;

    always_comb begin
        stat_clr  = (wr_i && addr_i == A_STAT) ? wdata_i : '0;
        base_wr   = wr_i && addr_i == A_BASE;
        tflag_clr = wr_i && addr_i == A_TFLAG && wdata_i[0];
    end

    hirq_status u_status (
        .clk    (clk),
        .rst_n  (rst_n),
        .ev_i   (ev_i),
        .clr_i  (stat_clr),
        .stat_o (stat_q)
    );

    hirq_timer #(.CNT_W(STAT_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .base_wr_i  (base_wr),
        .base_i     (wdata_i),
        .flag_clr_i (tflag_clr),
        .base_o     (base_q),
        .cnt_o      (cnt_q),
        .flag_o     (tflag_q)
    );

    hirq_pin u_pin (
        .clk     (clk),
        .rst_n   (rst_n),
        .stat_i  (stat_q),
        .en_i    (en_i),
        .tflag_i (tflag_q),
        .ten_i   (tmr_en_i),
        .irq_n_o (irq_n_o)
    );

    always_comb begin
        unique case (addr_i)
            A_STAT:  rdata_o = stat_q;
            A_BASE:  rdata_o = base_q;
            A_CNT:   rdata_o = cnt_q;
            default: rdata_o = {{(STAT_W-1){1'b0}}, tflag_q};
        endcase
    end
endmodule

// File: rtl/hirq_aggr_chk.sv
module hirq_aggr_chk
    import hirq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [STAT_W-1:0] ev_i,
    input logic [STAT_W-1:0] en_i,
    input logic              wr_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [STAT_W-1:0] wdata_i,
    input logic              irq_n_o,
    input logic [STAT_W-1:0] stat_q,
    input logic [STAT_W-1:0] base_q,
    input logic [STAT_W-1:0] cnt_q,
    input logic              tflag_q
);
    // R1
    src_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(ev_i & SRC_MASK)) |=>
            ((stat_q & $past(ev_i & SRC_MASK)) == $past(ev_i & SRC_MASK)));

    // R2
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q & ~SRC_MASK) == '0);

    // R3
    w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == 2'd0 && ev_i == '0) |=>
            (stat_q == ($past(stat_q) & ~$past(wdata_i))));

    // R5
    pin_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(stat_q & en_i)) |=> !irq_n_o);

    // R7
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (base_q != '0 && cnt_q == 16'd1 && !(wr_i && addr_i == 2'd1)) |=>
            (cnt_q == $past(base_q) && tflag_q));

    // R8
    base_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (base_q == '0 && !(wr_i && addr_i == 2'd1)) |=>
            (cnt_q == '0 && !$rose(tflag_q)));
endmodule

bind hirq_aggr hirq_aggr_chk u_chk (.*);

// File: tb/hirq_aggr_bench.sv
`timescale 1ns/1ps
module hirq_aggr_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] ev_i = '0;
    logic [15:0] en_i = '0;
    logic        tmr_en_i = 1'b0;
    logic        wr_i = 1'b0;
    logic [1:0]  addr_i = '0;
    logic [15:0] wdata_i = '0;
    logic [15:0] rdata_o;
    logic        irq_n_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    hirq_aggr u_hirq_aggr (
        .clk(clk), .rst_n(rst_n), .ev_i(ev_i), .en_i(en_i), .tmr_en_i(tmr_en_i),
        .wr_i(wr_i), .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
        .irq_n_o(irq_n_o)
    );

    typedef struct packed {
        logic [15:0] ev;
        logic        wr;
        logic [15:0] wd;
        logic [15:0] exp;
    } vec_t;

    // status-register vectors: event, clear write, expected status afterwards
    localparam vec_t VEC [9] = '{
        '{16'h0002, 1'b0, 16'h0000, 16'h0002},  // R1 rx0
        '{16'h8601, 1'b0, 16'h0000, 16'h0002},  // R2 reserved pulses
        '{16'h0018, 1'b0, 16'h0000, 16'h001A},  // R1 tx0 tx1
        '{16'h7800, 1'b0, 16'h0000, 16'h781A},  // R1 wake and aborts
        '{16'h01E0, 1'b0, 16'h0000, 16'h79FA},  // R1 mailboxes
        '{16'h0000, 1'b1, 16'h000A, 16'h79F0},  // R3 partial clear
        '{16'h0010, 1'b1, 16'hFFFF, 16'h0010},  // R4 set beats clear
        '{16'h0000, 1'b1, 16'h0000, 16'h0010},  // R3 zero write
        '{16'h0000, 1'b1, 16'h0010, 16'h0000}   // R3 final clear
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] v);
        addr_i = a;
        #1;
        v = rdata_o;
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        // R10 reset state
        rd(2'd0, v); check("R10 status", v, 16'h0000);
        rd(2'd2, v); check("R10 count", v, 16'h0000);
        rd(2'd3, v); check("R10 tflag", v, 16'h0000);
        check("R10 irq_n", {15'd0, irq_n_o}, 16'h0001);
        rst_n = 1'b1;
        tick();

        foreach (VEC[i]) begin
            ev_i = VEC[i].ev; wr_i = VEC[i].wr; wdata_i = VEC[i].wd; addr_i = 2'd0;
            tick();
            ev_i = '0; wr_i = 1'b0; wdata_i = '0;
            rd(2'd0, v);
            check($sformatf("R1-vector %0d (R2 R3 R4)", i), v, VEC[i].exp);
        end

        // R6: one edge between status and pin
        en_i = 16'h0002; ev_i = 16'h0002;
        tick();
        ev_i = '0;
        check("R6 pin still high", {15'd0, irq_n_o}, 16'h0001);
        tick();
        check("R5 pin low on enabled bit", {15'd0, irq_n_o}, 16'h0000);
        en_i = 16'h0000;
        tick();
        check("R5 masked bit leaves pin high", {15'd0, irq_n_o}, 16'h0001);
        wr_i = 1'b1; addr_i = 2'd0; wdata_i = 16'hFFFF;
        tick();
        wr_i = 1'b0;

        // R7 timer with base 3
        tmr_en_i = 1'b1;
        wr_i = 1'b1; addr_i = 2'd1; wdata_i = 16'd3;
        tick();
        wr_i = 1'b0;
        rd(2'd2, v); check("R7 count loaded", v, 16'd3);
        rd(2'd1, v); check("R7 base readback", v, 16'd3);
        tick();
        tick();
        rd(2'd2, v); check("R7 count down", v, 16'd1);
        rd(2'd3, v); check("R7 no early flag", v, 16'd0);
        tick();
        rd(2'd3, v); check("R7 flag on expiry", v, 16'd1);
        rd(2'd2, v); check("R7 reload", v, 16'd3);
        wr_i = 1'b1; addr_i = 2'd3; wdata_i = 16'h0001;
        tick();
        wr_i = 1'b0;
        rd(2'd3, v); check("R9 flag cleared", v, 16'd0);
        check("R9 flag drove pin", {15'd0, irq_n_o}, 16'h0000);
        tick();
        check("R9 pin released", {15'd0, irq_n_o}, 16'h0001);

        // R8 base zero stops the timer
        wr_i = 1'b1; addr_i = 2'd1; wdata_i = 16'd0;
        tick();
        wr_i = 1'b0;
        repeat (10) tick();
        rd(2'd2, v); check("R8 count held", v, 16'd0);
        rd(2'd3, v); check("R8 no flag", v, 16'd0);
        check("R8 pin high", {15'd0, irq_n_o}, 16'h0001);

        finish_run();
    end
endmodule